// File: doc/BRIEF.md
# Error Event Queue with Loss Marker

This block holds error events for later pickup by a host. Each event is a signed 16-bit code. Producers present a code on a push strobe. A consumer sees the oldest stored code on a head output and removes it with a pop strobe. The queue has `DEPTH` entries (default 8). A single not-empty flag drives bit 2 of the instrument's status summary byte.

When a producer pushes into a full queue, the code is not stored. Instead the most recently stored entry is rewritten with the loss marker code -350. A reader draining the queue therefore finds the marker where the lost events would have been. Pushes that arrive after the marker is in place are discarded until a pop makes room. A synchronous clear input empties the queue in one cycle.

Top module: `err_queue`

## Requirements
- R1: Codes come out on `head_code_o` in the same order in which they were pushed, and each pop removes exactly the code shown on `head_code_o` in that cycle.
- R2: When the queue is empty, `head_code_o` is 0 (no error). A pop on an empty queue changes no state: the queue stays empty, and a later push is stored and shown normally.
- R3: A push without a pop while the queue holds `DEPTH` entries stores nothing new. It rewrites the newest entry with -350 (16'hFEA2), and the occupancy stays at `DEPTH`.
- R4: While the queue is full and the newest entry holds the marker, further pushes without a pop are discarded. Draining then yields the first `DEPTH-1` codes followed by a single -350.
- R5: `not_empty_o` is 1 exactly when the queue holds at least one entry.
- R6: A push and a pop in the same cycle on a non-empty queue that is not full both take effect, and the occupancy is unchanged.
- R7: A push and a pop in the same cycle on a full queue remove the head and append the pushed code unchanged, with no marker substitution.
- R8: `clr_i` empties the queue at the next clock edge and takes priority over push and pop in that cycle.
- R9: After reset the queue is empty: `not_empty_o` is 0 and `head_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all entries |
| push_i | input | 1 | Push strobe for a new error code |
| push_code_i | input | 16 | Signed error code to push |
| pop_i | input | 1 | Removes the head entry |
| head_code_o | output | 16 | Oldest stored code, or 0 when empty |
| not_empty_o | output | 1 | Queue holds at least one entry (status bit 2) |

## Verification
The bound checker enforces several rules on every cycle. The flag must agree with the occupancy, and the head must read 0 whenever the queue is empty. Occupancy must never exceed the depth, and it must hold steady under a simultaneous push and pop. A marker substitution must never fire on a full queue that is also being popped. A clear must leave the queue empty at the next edge. Only the bench's scenarios can show that codes emerge in push order and that the marker sits in the newest slot after an overflow. They also show that discarded pushes truly vanish, and that a pop on an empty queue leaves the pointers usable.

// File: rtl/err_q_pkg.sv
package err_q_pkg;
  localparam int CODE_W = 16;
  typedef logic signed [CODE_W-1:0] err_code_t;
  localparam err_code_t LOSS_CODE = -16'sd350;
  localparam err_code_t NO_ERR    = '0;
endpackage

// File: rtl/err_q_ptr.sv
module err_q_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= step_ptr(ptr);
  end
endmodule

// File: rtl/err_q_store.sv
module err_q_store
  import err_q_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  err_code_t        wdata,
  input  logic [PTR_W-1:0] raddr,
  output err_code_t        rdata
);
  err_code_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/err_q_ctrl.sv
module err_q_ctrl #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  output logic             do_push,
  output logic             do_pop,
  output logic             do_mark,
  output logic [CNT_W-1:0] cnt,
  output logic             not_empty
);
  logic is_full;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c,
                                                 input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign not_empty = (cnt != '0);
  assign is_full   = (cnt == CNT_W'(DEPTH));
  assign do_pop    = !clr && pop && not_empty;
  assign do_push   = !clr && push && (!is_full || do_pop);
  assign do_mark   = !clr && push && is_full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= next_cnt(cnt, do_push, do_pop);
  end
endmodule

// File: rtl/err_queue.sv
module err_queue
  import err_q_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        push_i,
  input  logic [15:0] push_code_i,
  input  logic        pop_i,
  output logic [15:0] head_code_o,
  output logic        not_empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             ev_push, ev_pop, ev_mark;
  logic [CNT_W-1:0] occ;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, newest_ptr, waddr;
  err_code_t        wdata, rdata;

  function automatic logic [PTR_W-1:0] back_ptr(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH-1) : p - 1'b1;
  endfunction

  err_q_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .push(push_i), .pop(pop_i),
    .do_push(ev_push), .do_pop(ev_pop), .do_mark(ev_mark),
    .cnt(occ), .not_empty(not_empty_o)
  );

  err_q_ptr #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .adv(ev_push), .ptr(wr_ptr)
  );

  err_q_ptr #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .adv(ev_pop), .ptr(rd_ptr)
  );

  assign newest_ptr = back_ptr(wr_ptr);
  assign waddr      = ev_mark ? newest_ptr : wr_ptr;
  assign wdata      = ev_mark ? LOSS_CODE : err_code_t'(push_code_i);

  err_q_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(ev_push | ev_mark), .waddr(waddr), .wdata(wdata),
    .raddr(rd_ptr), .rdata(rdata)
  );

  assign head_code_o = not_empty_o ? rdata : NO_ERR;
endmodule

// File: rtl/err_queue_chk.sv
module err_queue_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [15:0]      head_code_o,
  input logic             not_empty_o,
  input logic [CNT_W-1:0] occ,
  input logic             ev_mark
);
  assert_flag_tracks_occ_R5: assert property (@(posedge clk) disable iff (!rst_n)
    not_empty_o == (occ != '0));

  assert_empty_head_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty_o |-> head_code_o == 16'h0000);

  assert_pop_empty_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty_o && pop_i && !push_i && !clr_i) |=> !not_empty_o);

  assert_no_overfill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_mark_keeps_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |=> occ == CNT_W'(DEPTH));

  assert_both_hold_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && not_empty_o && !clr_i) |=> occ == $past(occ));

  assert_full_both_no_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && push_i && pop_i) |-> !ev_mark);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!not_empty_o && occ == '0));
endmodule

bind err_queue err_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .push_i(push_i), .pop_i(pop_i),
  .head_code_o(head_code_o), .not_empty_o(not_empty_o),
  .occ(occ), .ev_mark(ev_mark)
);

// File: tb/err_queue_tb_top.sv
module err_queue_tb_top;
  localparam int DEPTH = 8;
  localparam logic [15:0] LOSS = 16'hFEA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [15:0] push_code_i = '0;
  logic [15:0] head_code_o;
  logic        not_empty_o;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  err_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .push_i(push_i),
    .push_code_i(push_code_i), .pop_i(pop_i),
    .head_code_o(head_code_o), .not_empty_o(not_empty_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic pu, input logic [15:0] code, input logic po, input logic cl);
    push_i = pu; push_code_i = code; pop_i = po; clr_i = cl;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    check(req, head_code_o, exp);
    step(1'b0, 16'h0, 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    check("R9 flag", {15'd0, not_empty_o}, 16'd0);
    check("R9 head", head_code_o, 16'd0);
  endtask

  task automatic t_order;
    step(1'b1, 16'hFF9C, 1'b0, 1'b0);
    check("R5 flag after push", {15'd0, not_empty_o}, 16'd1);
    step(1'b1, 16'h0071, 1'b0, 1'b0);
    step(1'b1, 16'h8000, 1'b0, 1'b0);
    pop_expect("R1 first", 16'hFF9C);
    pop_expect("R1 second", 16'h0071);
    pop_expect("R1 third", 16'h8000);
    check("R5 flag drained", {15'd0, not_empty_o}, 16'd0);
  endtask

  task automatic t_pop_empty;
    step(1'b0, 16'h0, 1'b1, 1'b0);
    check("R2 head empty", head_code_o, 16'd0);
    check("R2 flag empty", {15'd0, not_empty_o}, 16'd0);
    step(1'b1, 16'h1234, 1'b0, 1'b0);
    check("R2 push after empty pop", head_code_o, 16'h1234);
    pop_expect("R2 drain", 16'h1234);
    check("R2 empty again", {15'd0, not_empty_o}, 16'd0);
  endtask

  task automatic t_overflow;
    for (int i = 1; i <= DEPTH; i++) step(1'b1, 16'(i), 1'b0, 1'b0);
    step(1'b1, 16'd100, 1'b0, 1'b0);
    step(1'b1, 16'd200, 1'b0, 1'b0);
    step(1'b1, 16'd300, 1'b0, 1'b0);
    for (int i = 1; i < DEPTH; i++) pop_expect("R4 survivors", 16'(i));
    pop_expect("R3 marker in newest slot", LOSS);
    check("R4 nothing beyond marker", {15'd0, not_empty_o}, 16'd0);
    check("R2 head after drain", head_code_o, 16'd0);
  endtask

  task automatic t_both;
    step(1'b1, 16'd10, 1'b0, 1'b0);
    step(1'b1, 16'd11, 1'b0, 1'b0);
    check("R6 head before", head_code_o, 16'd10);
    step(1'b1, 16'd12, 1'b1, 1'b0);
    check("R6 head after", head_code_o, 16'd11);
    pop_expect("R6 second", 16'd11);
    pop_expect("R6 pushed", 16'd12);
    check("R6 occupancy kept", {15'd0, not_empty_o}, 16'd0);
  endtask

  task automatic t_full_both;
    for (int i = 1; i <= DEPTH; i++) step(1'b1, 16'(i + 40), 1'b0, 1'b0);
    step(1'b1, 16'd99, 1'b1, 1'b0);
    for (int i = 2; i <= DEPTH; i++) pop_expect("R7 survivors", 16'(i + 40));
    pop_expect("R7 pushed unchanged", 16'd99);
    check("R7 empty", {15'd0, not_empty_o}, 16'd0);
  endtask

  task automatic t_clear;
    for (int i = 0; i < 3; i++) step(1'b1, 16'(i + 7), 1'b0, 1'b0);
    step(1'b1, 16'd55, 1'b1, 1'b1);
    check("R8 flag", {15'd0, not_empty_o}, 16'd0);
    check("R8 head", head_code_o, 16'd0);
    step(1'b1, 16'd5, 1'b0, 1'b0);
    check("R8 push after clear", head_code_o, 16'd5);
    pop_expect("R8 drain", 16'd5);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_pop_empty();
    t_overflow();
    t_both();
    t_full_both();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule